// File: doc/BRIEF.md
# Delta Sample Playback Timer and Completion Control

This block paces a delta-modulation sample channel and decides what happens when a sample finishes. A 4-bit rate index picks a timer period, in CPU cycles, from a fixed non-linear table of sixteen entries. The timer counts on every CPU cycle and raises a one-cycle bit-clock tick each time it expires, so the tick rate is the CPU clock divided by the selected entry.

A bytes-remaining counter is loaded from a 12-bit length register by a start command and counts down once per consumed-byte strobe. When the last byte is consumed, the block either reloads the length and pulses a restart output (loop set), or raises a sticky IRQ flag (loop clear, IRQ enabled). A status write clears the flag, and so does a configuration write that disables the IRQ. Memory fetch, DMA and the output level are handled elsewhere.

Top module: `dmod_play_ctrl`

## Requirements
- R1: After reset, tick_o, restart_o and irq_o are low, remain_o is 0, the rate index is 0, loop and IRQ enable are clear, and the first tick_o appears on the 427th rising edge after reset is released.
- R2: The spacing between consecutive tick_o pulses is exactly the table entry for the rate index in use, where indices 0 through 15 map to 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54 cycles; tick_o is high for one cycle.
- R3: A new rate index written with cfg_we_i does not cut short the countdown in progress; it first applies at the next reload, the edge on which tick_o is high.
- R4: start_i loads the 12-bit length last written with len_we_i into remain_o on the next edge.
- R5: Each byte_take_i decrements remain_o by one; byte_take_i with remain_o equal to 0 is ignored, and remain_o changes only on start_i or byte_take_i.
- R6: With loop set, the byte_take_i that takes remain_o from 1 reloads the length and drives restart_o high for exactly the following cycle; irq_o is not set.
- R7: With loop clear and IRQ enable set, the byte_take_i that takes remain_o from 1 to 0 sets irq_o on the next edge, and irq_o stays high until cleared.
- R8: With loop clear and IRQ enable clear, reaching 0 leaves irq_o low and restart_o low.
- R9: A status write (stat_we_i) clears irq_o; if it coincides with a completion that sets irq_o, the set wins.
- R10: A configuration write with cfg_irq_en_i low clears a pending irq_o.
- R11: When start_i and byte_take_i coincide, the start wins: remain_o takes the length and no completion occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for rate, loop and IRQ enable |
| cfg_rate_i | input | 4 | Rate index to table |
| cfg_loop_i | input | 1 | Loop flag value |
| cfg_irq_en_i | input | 1 | IRQ enable value |
| len_we_i | input | 1 | Write strobe for length |
| len_i | input | 12 | Sample length in bytes |
| start_i | input | 1 | Load bytes-remaining from length |
| stat_we_i | input | 1 | Status write, clears IRQ |
| byte_take_i | input | 1 | One sample byte consumed |
| tick_o | output | 1 | Bit-clock strobe on timer expiry |
| restart_o | output | 1 | One-cycle pulse on looped restart |
| irq_o | output | 1 | Playback-complete IRQ flag |
| remain_o | output | 12 | Bytes remaining |

## Verification
The assertions assume every input strobe is a clean synchronous level sampled at the rising edge and that byte_take_i only comes from the consumer, without further pacing assumed. Checks on remain_o and irq_o take the current register values as given, so they hold for any mix of coinciding start, take and status writes. The bench drives all strobes for exactly one cycle from the falling edge and uses only combinations the requirements define, including the deliberate start/take and set/clear collisions.

// File: rtl/dmod_pkg.sv
package dmod_pkg;
  localparam int RATE_W = 4;
  localparam int LEN_W  = 12;
  localparam int PER_W  = 9;

  // Timer period in CPU cycles per rate index
  function automatic logic [PER_W-1:0] rate_period(input logic [RATE_W-1:0] idx);
    logic [PER_W-1:0] p;
    case (idx)
      4'd0:  p = 9'd428;
      4'd1:  p = 9'd380;
      4'd2:  p = 9'd340;
      4'd3:  p = 9'd320;
      4'd4:  p = 9'd286;
      4'd5:  p = 9'd254;
      4'd6:  p = 9'd226;
      4'd7:  p = 9'd214;
      4'd8:  p = 9'd190;
      4'd9:  p = 9'd160;
      4'd10: p = 9'd142;
      4'd11: p = 9'd128;
      4'd12: p = 9'd106;
      4'd13: p = 9'd84;
      4'd14: p = 9'd72;
      default: p = 9'd54;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/dmod_rate_timer.sv
module dmod_rate_timer
  import dmod_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam logic [PER_W-1:0] RST_LOAD = rate_period('0) - 1'b1;

  logic [PER_W-1:0] cnt_q;

  // rate_i is sampled only at reload, so a write never shortens a running period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= RST_LOAD;
    else if (cnt_q == '0)   cnt_q <= rate_period(rate_i) - 1'b1;
    else                    cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/dmod_byte_tracker.sv
module dmod_byte_tracker #(
  parameter int LEN_W = dmod_pkg::LEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             take_i,
  input  logic             loop_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] remain_o,
  output logic             done_o,
  output logic             restart_o
);
  logic [LEN_W-1:0] remain_q;
  logic             restart_q;
  logic             last_byte;

  assign last_byte = (remain_q == LEN_W'(1));
  assign done_o    = take_i && !start_i && last_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q  <= '0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= done_o && loop_i;
      if (start_i)
        remain_q <= len_i;
      else if (take_i && remain_q != '0) begin
        if (last_byte && loop_i) remain_q <= len_i;
        else                     remain_q <= remain_q - 1'b1;
      end
    end
  end

  assign remain_o  = remain_q;
  assign restart_o = restart_q;
endmodule

// File: rtl/dmod_irq_ctrl.sv
module dmod_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic loop_i,
  input  logic irq_en_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  // set has priority so a completion is never lost to a racing clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          irq_q <= 1'b0;
    else if (done_i && !loop_i && irq_en_i) irq_q <= 1'b1;
    else if (clr_i)                       irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dmod_play_ctrl.sv
module dmod_play_ctrl
  import dmod_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [RATE_W-1:0] cfg_rate_i,
  input  logic              cfg_loop_i,
  input  logic              cfg_irq_en_i,
  input  logic              len_we_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              start_i,
  input  logic              stat_we_i,
  input  logic              byte_take_i,
  output logic              tick_o,
  output logic              restart_o,
  output logic              irq_o,
  output logic [LEN_W-1:0]  remain_o
);
  logic [RATE_W-1:0] rate_q;
  logic              loop_q;
  logic              irq_en_q;
  logic [LEN_W-1:0]  len_q;
  logic              done;
  logic              irq_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q   <= '0;
      loop_q   <= 1'b0;
      irq_en_q <= 1'b0;
      len_q    <= '0;
    end else begin
      if (cfg_we_i) begin
        rate_q   <= cfg_rate_i;
        loop_q   <= cfg_loop_i;
        irq_en_q <= cfg_irq_en_i;
      end
      if (len_we_i) len_q <= len_i;
    end
  end

  assign irq_clr = stat_we_i || (cfg_we_i && !cfg_irq_en_i);

  dmod_rate_timer u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rate_i (rate_q),
    .tick_o (tick_o)
  );

  dmod_byte_tracker #(.LEN_W(LEN_W)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .take_i    (byte_take_i),
    .loop_i    (loop_q),
    .len_i     (len_q),
    .remain_o  (remain_o),
    .done_o    (done),
    .restart_o (restart_o)
  );

  dmod_irq_ctrl u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done),
    .loop_i   (loop_q),
    .irq_en_i (irq_en_q),
    .clr_i    (irq_clr),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/dmod_play_ctrl_chk.sv
module dmod_play_ctrl_chk
  import dmod_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              stat_we_i,
  input logic              byte_take_i,
  input logic              tick_o,
  input logic              restart_o,
  input logic              irq_o,
  input logic [LEN_W-1:0]  remain_o
);
  localparam logic [PER_W-1:0] MAX_PER = rate_period('0);

  logic [PER_W-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gap_q <= '0;
    else if (tick_o) gap_q <= '0;
    else             gap_q <= gap_q + 1'b1;
  end

  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q < MAX_PER);

  assert_tick_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  assert_start_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !byte_take_i |=> $stable(remain_o));

  assert_decrement_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_take_i && !start_i && remain_o > LEN_W'(1) |=> remain_o == $past(remain_o) - 1'b1);

  assert_restart_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> $past(byte_take_i && !start_i && remain_o == LEN_W'(1)));

  assert_irq_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(byte_take_i && !start_i && remain_o == LEN_W'(1)));

  assert_irq_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> !$rose(irq_o));

  assert_irq_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i && !byte_take_i |=> !irq_o);
endmodule

bind dmod_play_ctrl dmod_play_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .stat_we_i   (stat_we_i),
  .byte_take_i (byte_take_i),
  .tick_o      (tick_o),
  .restart_o   (restart_o),
  .irq_o       (irq_o),
  .remain_o    (remain_o)
);

// File: tb/dmod_play_ctrl_tb.sv
`timescale 1ns/1ps
module dmod_play_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_rate_i = '0;
  logic        cfg_loop_i = 1'b0;
  logic        cfg_irq_en_i = 1'b0;
  logic        len_we_i = 1'b0;
  logic [11:0] len_i = '0;
  logic        start_i = 1'b0;
  logic        stat_we_i = 1'b0;
  logic        byte_take_i = 1'b0;
  logic        tick_o, restart_o, irq_o;
  logic [11:0] remain_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  dmod_play_ctrl u_dut (.*);

  function automatic int exp_period(input int idx);
    case (idx)
      0: return 428;  1: return 380;  2: return 340;  3: return 320;
      4: return 286;  5: return 254;  6: return 226;  7: return 214;
      8: return 190;  9: return 160; 10: return 142; 11: return 128;
      12: return 106; 13: return 84; 14: return 72; default: return 54;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic cfg_w(input int rate, input bit lp, input bit en);
    cfg_rate_i = rate[3:0]; cfg_loop_i = lp; cfg_irq_en_i = en; cfg_we_i = 1'b1;
    cyc();
    cfg_we_i = 1'b0;
  endtask

  task automatic load(input int len);
    len_i = len[11:0]; len_we_i = 1'b1;
    cyc();
    len_we_i = 1'b0; start_i = 1'b1;
    cyc();
    start_i = 1'b0;
  endtask

  task automatic take();
    byte_take_i = 1'b1;
    cyc();
    byte_take_i = 1'b0;
  endtask

  task automatic wait_tick();
    for (int i = 0; i < 1000 && !tick_o; i++) cyc();
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin cyc(); n++; end while (!tick_o && n < 1000);
  endtask

  task automatic t_reset();
    int n;
    check("R1 tick", tick_o, 0);
    check("R1 restart", restart_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 remain", remain_o, 0);
    n = 0;
    while (!tick_o && n < 1000) begin cyc(); n++; end
    check("R1 first tick edge", n, 427);
    gap(n);
    check("R2 idx0 period", n, 428);
  endtask

  task automatic t_period(input int idx);
    int n;
    cfg_w(idx, 1'b0, 1'b0);
    wait_tick();
    gap(n);
    check($sformatf("R2 idx%0d period", idx), n, exp_period(idx));
    cyc();
    check("R2 tick one cycle", tick_o, 0);
  endtask

  task automatic t_rate_change();
    int n;
    wait_tick();
    cfg_rate_i = 4'd0; cfg_we_i = 1'b1;
    cyc();
    cfg_we_i = 1'b0;
    n = 1;
    while (!tick_o && n < 1000) begin cyc(); n++; end
    check("R3 old period completes", n, 54);
    gap(n);
    check("R3 new period applies", n, 428);
  endtask

  task automatic t_count();
    cfg_w(15, 1'b0, 1'b0);
    load(5);
    check("R4 start load", remain_o, 5);
    take(); take(); take();
    check("R5 decrement", remain_o, 2);
    cyc(); cyc();
    check("R5 hold without take", remain_o, 2);
    take(); take();
    check("R8 reach zero", remain_o, 0);
    check("R8 no irq", irq_o, 0);
    check("R8 no restart", restart_o, 0);
    take();
    check("R5 take at zero ignored", remain_o, 0);
    load(4095);
    check("R4 full width", remain_o, 4095);
  endtask

  task automatic t_loop();
    cfg_w(15, 1'b1, 1'b1);
    load(3);
    take(); take();
    check("R6 before end", restart_o, 0);
    take();
    check("R6 reload", remain_o, 3);
    check("R6 restart pulse", restart_o, 1);
    check("R6 no irq", irq_o, 0);
    cyc();
    check("R6 pulse one cycle", restart_o, 0);
  endtask

  task automatic t_irq();
    cfg_w(15, 1'b0, 1'b1);
    load(2);
    take();
    check("R7 not yet", irq_o, 0);
    take();
    check("R7 irq set", irq_o, 1);
    check("R7 remain zero", remain_o, 0);
    cyc(); cyc(); cyc();
    check("R7 irq sticky", irq_o, 1);
    stat_we_i = 1'b1;
    cyc();
    stat_we_i = 1'b0;
    check("R9 status clear", irq_o, 0);
  endtask

  task automatic t_clear_en();
    load(1);
    take();
    check("R10 setup irq", irq_o, 1);
    cfg_w(15, 1'b0, 1'b0);
    check("R10 disable clears irq", irq_o, 0);
    cfg_w(15, 1'b0, 1'b1);
  endtask

  task automatic t_set_wins();
    load(1);
    byte_take_i = 1'b1; stat_we_i = 1'b1;
    cyc();
    byte_take_i = 1'b0; stat_we_i = 1'b0;
    check("R9 set wins over clear", irq_o, 1);
    stat_we_i = 1'b1;
    cyc();
    stat_we_i = 1'b0;
  endtask

  task automatic t_start_prio();
    load(1);
    len_i = 12'd7; len_we_i = 1'b1;
    cyc();
    len_we_i = 1'b0;
    start_i = 1'b1; byte_take_i = 1'b1;
    cyc();
    start_i = 1'b0; byte_take_i = 1'b0;
    check("R11 start wins remain", remain_o, 7);
    check("R11 no completion irq", irq_o, 0);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst_ni = 1'b1;
    t_reset();
    t_period(15);
    t_period(5);
    t_period(9);
    t_period(12);
    t_period(15);
    t_rate_change();
    t_count();
    t_loop();
    t_irq();
    t_clear_en();
    t_set_wins();
    t_start_prio();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule